// File: doc/BRIEF.md
# GPIO Interrupt Controller

A 32-pin general-purpose I/O controller behind a simple word-wide register bus. Software sets the direction and the output level of each pin, and reads back a data word that combines driven levels with sampled input levels. Every pin input is brought into the clock domain through a two-flop synchroniser. An edge detector then latches qualifying transitions into a sticky event register.

Software acknowledges events by writing ones to the event register. A mask register decides which pending events reach the single interrupt output. The block also presents the number of the lowest-numbered pending, enabled pin, together with a valid flag.

The edge sense per pin is one bit by default: falling only, or both edges. A build parameter selects a two-bit sense code instead, spread over two configuration registers. Pin numbering is reversed against bit order: pin n lives in register bit 31-n throughout.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads zero, `pin_oe`, `pin_out`, `od_en` are zero, and `irq` and `pend_vld` are low.
- R2: Register word index `addr[4:2]`: 0 direction, 1 open-drain, 2 data, 3 event, 4 mask, 5 sense, 6 second sense. `pin_oe` follows the direction register (1 = output) and `pin_out` follows the data register, bit 31-n belonging to pin n.
- R3: A data read returns the stored output bit for pins whose direction bit is 1, and the synchronised input level for pins whose direction bit is 0.
- R4: The open-drain register stores the written word, drives `od_en` and reads back unchanged.
- R5: Writing to the event register clears exactly the bits written as 1 and leaves the others. When a new edge and a clearing write meet on one bit in the same cycle, the bit stays set.
- R6: `irq` is high exactly while some bit is set in both the event and the mask register; a mask bit of 1 enables its pin.
- R7: With `WIDE_SENSE`=0, a sense bit of 1 latches only falling edges (1 to 0), and a sense bit of 0 latches rising and falling edges; a steady level latches nothing.
- R8: With `WIDE_SENSE`=1, pins 0-15 take a two-bit code from the sense register and pins 16-31 from the second sense register, at bit offset 2*(15 - (p mod 16)). Code 2'b10 means falling only, 2'b01 rising only, 2'b00 both edges, and 2'b11 latches nothing.
- R9: `pend_vld` is high while any enabled event is pending. `pend_id` then gives the lowest pin number among them.
- R10: With `WIDE_SENSE`=0, the second sense register reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Byte address; bits 4:2 pick the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pin_in | input | 32 | Pad input levels |
| pin_out | output | 32 | Output levels to pads |
| pin_oe | output | 32 | Output enables to pads |
| od_en | output | 32 | Open-drain selection to pads |
| irq | output | 1 | Combined interrupt |
| pend_id | output | 5 | Number of the lowest pending, enabled pin |
| pend_vld | output | 1 | `pend_id` is meaningful |

## Verification
The bench goes after the same-cycle collision between a fresh edge and a clearing write. A design that lets the clear win would silently drop that event.

It walks every sense setting against each start and end level. A detector wired to the wrong polarity would latch rising edges in falling-only mode. The bench also checks the reversed pin order in both sense variants. A design with a mis-shifted two-bit field would apply one pin's code to its neighbour.

Finally, the bench checks that the pending-pin number tracks the mask. A priority encoder scanning from the wrong end would report pin 3 instead of pin 0.

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter bit WIDE_SENSE = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [4:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic [31:0] pin_in,
  output logic [31:0] pin_out,
  output logic [31:0] pin_oe,
  output logic [31:0] od_en,
  output logic        irq,
  output logic [4:0]  pend_id,
  output logic        pend_vld
);
  localparam int NP = 32;
  localparam int HALF = NP / 2;
  localparam logic [2:0] A_DIR = 3'd0, A_ODR = 3'd1, A_DAT = 3'd2, A_EVT = 3'd3,
                         A_MSK = 3'd4, A_SNS = 3'd5, A_SNS2 = 3'd6;

  logic [NP-1:0] dir_q, od_q, dat_q, evt_q, msk_q, sns_q, sns2_q;
  logic [NP-1:0] s1_q, s2_q, s3_q, det, clr, act;
  logic [2:0] widx;
  logic unused_lsb;

  assign widx       = addr[4:2];
  assign unused_lsb = ^addr[1:0];
  assign clr        = (wr_en && widx == A_EVT) ? wdata : '0;
  assign act        = evt_q & msk_q;
  assign irq        = |act;
  assign pin_out    = dat_q;
  assign pin_oe     = dir_q;
  assign od_en      = od_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= '0; od_q <= '0; dat_q <= '0; evt_q <= '0;
      msk_q <= '0; sns_q <= '0; sns2_q <= '0;
      s1_q <= '0; s2_q <= '0; s3_q <= '0;
    end else begin
      s1_q  <= pin_in;
      s2_q  <= s1_q;
      s3_q  <= s2_q;
      evt_q <= (evt_q & ~clr) | det;
      if (wr_en) begin
        case (widx)
          A_DIR:   dir_q <= wdata;
          A_ODR:   od_q  <= wdata;
          A_DAT:   dat_q <= wdata;
          A_MSK:   msk_q <= wdata;
          A_SNS:   sns_q <= wdata;
          A_SNS2:  if (WIDE_SENSE) sns2_q <= wdata;
          default: ;
        endcase
      end
    end
  end

  wire [NP-1:0] rise = s2_q & ~s3_q;
  wire [NP-1:0] fall = ~s2_q & s3_q;

  generate
    if (WIDE_SENSE) begin : g_wide
      for (genvar b = 0; b < NP; b++) begin : g_bit
        logic [1:0] code;
        if (b >= HALF) begin : g_first
          assign code = sns_q[2*(b-HALF) +: 2];
        end else begin : g_second
          assign code = sns2_q[2*b +: 2];
        end
        assign det[b] = (code == 2'b00 && (rise[b] || fall[b])) ||
                        (code == 2'b10 && fall[b]) ||
                        (code == 2'b01 && rise[b]);
      end
    end else begin : g_narrow
      assign det = fall | (rise & ~sns_q);
    end
  endgenerate

  always_comb begin
    case (widx)
      A_DIR:   rdata = dir_q;
      A_ODR:   rdata = od_q;
      A_DAT:   rdata = (dat_q & dir_q) | (s2_q & ~dir_q);
      A_EVT:   rdata = evt_q;
      A_MSK:   rdata = msk_q;
      A_SNS:   rdata = sns_q;
      A_SNS2:  rdata = sns2_q;
      default: rdata = '0;
    endcase
  end

  always_comb begin
    pend_vld = 1'b0;
    pend_id  = '0;
    for (int b = 0; b < NP; b++) begin
      if (act[b]) begin
        pend_vld = 1'b1;
        pend_id  = 5'(NP - 1 - b);
      end
    end
  end
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [4:0]  addr,
  input logic [31:0] wdata,
  input logic [31:0] pin_oe,
  input logic [31:0] evt_q,
  input logic [31:0] msk_q,
  input logic [31:0] det,
  input logic        irq,
  input logic [4:0]  pend_id,
  input logic        pend_vld
);
  // R5
  evt_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_q & ~$past(evt_q)) & ~$past(det)) == 32'h0);

  // R5
  evt_clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[4:2] == 3'd3 && wdata == 32'hFFFF_FFFF && det == 32'h0) |=> evt_q == 32'h0);

  // R6
  irq_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == pend_vld);

  // R9
  pend_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_vld |-> (evt_q[5'd31 - pend_id] && msk_q[5'd31 - pend_id]));

  // R2
  dir_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[4:2] == 3'd0) |=> pin_oe == $past(wdata));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .pin_oe(pin_oe), .evt_q(evt_q), .msk_q(msk_q), .det(det),
  .irq(irq), .pend_id(pend_id), .pend_vld(pend_vld)
);

// File: tb/gpio_irq_ctrl_test.sv
module gpio_irq_ctrl_test;
  localparam int PERIOD = 10;
  localparam logic [4:0] R_DIR = 5'h00, R_ODR = 5'h04, R_DAT = 5'h08, R_EVT = 5'h0C,
                         R_MSK = 5'h10, R_SNS = 5'h14, R_SNS2 = 5'h18;
  // {sense bit, start level, end level, expected event}
  localparam logic [3:0] VEC [8] = '{
    4'b0_0_1_1, 4'b0_1_0_1, 4'b0_0_0_0, 4'b0_1_1_0,
    4'b1_0_1_0, 4'b1_1_0_1, 4'b1_0_0_0, 4'b1_1_1_0
  };

  logic clk = 1'b0, rst_n = 1'b0, we1 = 1'b0, we2 = 1'b0;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0, pin_in = '0;
  logic [31:0] rd1, rd2, po1, po2, oe1, oe2, od1, od2;
  logic irq1, irq2, pv1, pv2;
  logic [4:0] pid1, pid2;
  int n_chk = 0, n_bad = 0;

  always #(PERIOD/2) clk = ~clk;

  gpio_irq_ctrl #(.WIDE_SENSE(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(we1), .addr(addr), .wdata(wdata), .rdata(rd1),
    .pin_in(pin_in), .pin_out(po1), .pin_oe(oe1), .od_en(od1),
    .irq(irq1), .pend_id(pid1), .pend_vld(pv1));

  gpio_irq_ctrl #(.WIDE_SENSE(1'b1)) uut_w (
    .clk(clk), .rst_n(rst_n), .wr_en(we2), .addr(addr), .wdata(wdata), .rdata(rd2),
    .pin_in(pin_in), .pin_out(po2), .pin_oe(oe2), .od_en(od2),
    .irq(irq2), .pend_id(pid2), .pend_vld(pv2));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input bit wide, input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we1 = !wide; we2 = wide;
    @(negedge clk);
    we1 = 1'b0; we2 = 1'b0;
  endtask

  task automatic rd(input bit wide, input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = wide ? rd2 : rd1;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rd(0, 5'(a * 4), r); chk("R1 narrow reg", r, 32'h0);
      rd(1, 5'(a * 4), r); chk("R1 wide reg", r, 32'h0);
    end
    chk("R1 outputs", {oe1, po1, od1} == 96'h0 ? 32'h0 : 32'h1, 32'h0);
    chk("R1 irq/vld", {30'h0, irq1, pv1}, 32'h0);

    // R2 direction and data
    wr(0, R_DAT, 32'h8000_0001);
    wr(0, R_DIR, 32'hF000_0001);
    chk("R2 pin_oe", oe1, 32'hF000_0001);
    chk("R2 pin_out", po1, 32'h8000_0001);

    // R3 mixed readback
    pin_in = 32'h0F00_FF00;
    settle();
    rd(0, R_DAT, r); chk("R3 data read", r, 32'h8F00_FF01);

    // R4 open-drain register
    wr(0, R_ODR, 32'h1234_5678);
    chk("R4 od_en", od1, 32'h1234_5678);
    rd(0, R_ODR, r); chk("R4 readback", r, 32'h1234_5678);

    wr(0, R_DIR, 32'h0);
    pin_in = 32'h0;
    settle();
    wr(0, R_EVT, 32'hFFFF_FFFF);
    wr(1, R_EVT, 32'hFFFF_FFFF);

    // R7 sense table walked on pin 5 (bit 26)
    for (int i = 0; i < 8; i++) begin
      logic [3:0] v;
      v = VEC[i];
      wr(0, R_SNS, v[3] ? 32'h0400_0000 : 32'h0);
      pin_in[26] = v[2];
      settle();
      wr(0, R_EVT, 32'hFFFF_FFFF);
      pin_in[26] = v[1];
      settle();
      rd(0, R_EVT, r);
      chk("R7 sense vector", {31'h0, r[26]}, {31'h0, v[0]});
    end
    pin_in = 32'h0;
    wr(0, R_SNS, 32'h0);
    settle();
    wr(0, R_EVT, 32'hFFFF_FFFF);

    // R6 / R9 pending selection, pins 0 and 3
    pin_in = 32'h9000_0000;
    settle();
    chk("R6 masked irq", {31'h0, irq1}, 32'h0);
    chk("R9 masked vld", {31'h0, pv1}, 32'h0);
    wr(0, R_MSK, 32'h1000_0000);
    chk("R6 enabled irq", {31'h0, irq1}, 32'h1);
    chk("R9 id pin3", {26'h0, pv1, pid1}, {26'h0, 1'b1, 5'd3});
    wr(0, R_MSK, 32'h9000_0000);
    chk("R9 id pin0", {26'h0, pv1, pid1}, {26'h0, 1'b1, 5'd0});

    // R5 selective clear
    wr(0, R_EVT, 32'h1000_0000);
    rd(0, R_EVT, r); chk("R5 selective clear", r, 32'h8000_0000);

    // R5 collision: pin 3 falls, clear lands on the detecting cycle
    @(negedge clk);
    pin_in[28] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    addr = R_EVT; wdata = 32'h1000_0000; we1 = 1'b1;
    @(negedge clk);
    we1 = 1'b0;
    rd(0, R_EVT, r); chk("R5 edge beats clear", r, 32'h9000_0000);
    wr(0, R_EVT, 32'hFFFF_FFFF);
    rd(0, R_EVT, r); chk("R5 clear all", r, 32'h0);
    chk("R6 irq drops", {31'h0, irq1}, 32'h0);

    // R10 narrow build ignores second sense register
    wr(0, R_SNS2, 32'hFFFF_FFFF);
    rd(0, R_SNS2, r); chk("R10 narrow sns2", r, 32'h0);

    // R8 wide sense: pin2=10, pin9=11, pin20=01, pin7=00
    pin_in = 32'h0;
    settle();
    wr(1, R_SNS, 32'h0800_3000);
    wr(1, R_SNS2, 32'h0040_0000);
    rd(1, R_SNS2, r); chk("R8 sns2 readback", r, 32'h0040_0000);
    wr(1, R_EVT, 32'hFFFF_FFFF);
    pin_in = 32'h2140_0800;
    settle();
    rd(1, R_EVT, r); chk("R8 rising", r, 32'h0100_0800);
    wr(1, R_EVT, 32'hFFFF_FFFF);
    pin_in = 32'h0;
    settle();
    rd(1, R_EVT, r); chk("R8 falling", r, 32'h2100_0000);

    summary();
    $finish;
  end
endmodule